// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block links two 18-bit buses, called A and B, with one storage element per direction. Each element has three behaviours, selected by a pass control and a capture clock for that direction. While the pass control is high, the far output follows the near input with no register delay, and the element keeps tracking that input. While the pass control is low, the element keeps its contents, except that a rising edge on the capture clock loads the near input. A separate enable for each direction decides whether the far bus is driven. The A-to-B enable is active high and the B-to-A enable is active low.

Both ports are split into an input vector, an output vector and a per-bit output-enable vector, so the block contains no internal tristate nets. Each port also has a "driven" flag. While that flag is low, the block keeps the last input value it saw and uses it in place of the raw input. This keeps a released bus at a defined level without pull resistors.

The capture clocks are treated as data. They are sampled on the system clock `clk`, and a rising edge is recognised as a low-to-high change between two successive samples.

Top module: `reg_bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage elements, both held-input registers and the sampled capture clocks. After reset, with the pass controls low and both ports undriven, `aOut` and `bOut` read zero.
- R2: While `leAb` is 1, `bOut` equals the effective A input in the same cycle, with no clock delay.
- R3: While `leAb` is 0 and `clkAb` has not risen, `bOut` keeps its value across system clock edges.
- R4: When `leAb` is 0 and `clkAb` is sampled 1 at a `clk` edge after being sampled 0 at the previous edge, the effective A input at that edge appears on `bOut` right after the edge.
- R5: When `leAb` falls, `bOut` keeps the effective A input that was sampled at the last `clk` edge while `leAb` was still 1.
- R6: `bOe` is all ones while `oeAb` is 1, and all zeros while `oeAb` is 0.
- R7: `aOe` is all ones while `oeBaN` is 0, and all zeros while `oeBaN` is 1.
- R8: The B-to-A path works like the A-to-B path, with `leBa`, `clkBa`, `bIn`/`bDrv` and `aOut` in place of `leAb`, `clkAb`, `aIn`/`aDrv` and `bOut`.
- R9: While a port's driven flag is 1, its effective input is the raw input, and the block registers that value at each `clk` edge. While the flag is 0, the effective input is the value registered at the last edge on which the flag was 1.
- R10: A falling edge of `clkAb` or `clkBa` captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture clocks and updates the registers |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 18 | A bus input level |
| aDrv | input | 1 | A bus is being driven externally |
| aOut | output | 18 | Value presented toward the A bus |
| aOe | output | 18 | Per-bit drive enable for the A bus |
| bIn | input | 18 | B bus input level |
| bDrv | input | 1 | B bus is being driven externally |
| bOut | output | 18 | Value presented toward the B bus |
| bOe | output | 18 | Per-bit drive enable for the B bus |
| leAb | input | 1 | A-to-B pass control, 1 = transparent |
| clkAb | input | 1 | A-to-B capture clock, loads on a rising edge |
| oeAb | input | 1 | B drive enable, active high |
| leBa | input | 1 | B-to-A pass control, 1 = transparent |
| clkBa | input | 1 | B-to-A capture clock, loads on a rising edge |
| oeBaN | input | 1 | A drive enable, active low |

## Verification
The hardest case to reach is one where a port is released and a capture or a pass event follows in the same direction. The value that then lands in storage must be the held level, not the raw input. The random stimulus releases each port about one cycle in four and toggles the capture clocks often, so held-input captures and transparent held-input windows occur many times. A directed sequence also forces a capture while the port is released and its raw input carries a different pattern. Further directed steps cover the cycle in which the pass control falls and a capture clock that falls with no load.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes sent from the control to the datapath, one set per direction
  typedef struct packed {
    logic passAb;  // A-to-B element tracks its input
    logic capAb;   // A-to-B element loads on this edge
    logic passBa;
    logic capBa;
  } xferStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        leAb,
  input  logic        clkAb,
  input  logic        leBa,
  input  logic        clkBa,
  output xferStrobe_t strobes
);
  logic clkAbQ, clkBaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkAbQ <= 1'b0;
      clkBaQ <= 1'b0;
    end else begin
      clkAbQ <= clkAb;
      clkBaQ <= clkBa;
    end
  end

  // A rising edge is a 0 sample followed by a 1 sample; pass mode wins
  always_comb begin
    strobes.passAb = leAb;
    strobes.passBa = leBa;
    strobes.capAb  = !leAb && clkAb && !clkAbQ;
    strobes.capBa  = !leBa && clkBa && !clkBaQ;
  end

  // One rising edge yields one capture, never two back to back
  AST_ONE_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capAb |=> !strobes.capAb); // R4
  AST_ONE_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capBa |=> !strobes.capBa); // R8
endmodule

// File: rtl/xcvr_dp.sv
module xcvr_dp
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic             aDrv,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bDrv,
  input  xferStrobe_t      strobes,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut
);
  logic [WIDTH-1:0] holdA, holdB;
  logic [WIDTH-1:0] storeAb, storeBa;
  logic [WIDTH-1:0] aEff, bEff;

  // Bus-hold: remember the last driven level of each port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdA <= '0;
      holdB <= '0;
    end else begin
      if (aDrv) holdA <= aIn;
      if (bDrv) holdB <= bIn;
    end
  end

  assign aEff = aDrv ? aIn : holdA;
  assign bEff = bDrv ? bIn : holdB;

  // Storage: follow in pass mode, load on a capture edge, else keep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeAb <= '0;
      storeBa <= '0;
    end else begin
      if (strobes.passAb || strobes.capAb) storeAb <= aEff;
      if (strobes.passBa || strobes.capBa) storeBa <= bEff;
    end
  end

  // Pass mode bypasses the storage combinationally
  assign bOut = strobes.passAb ? aEff : storeAb;
  assign aOut = strobes.passBa ? bEff : storeBa;

  AST_KEEP_AB: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.passAb && !strobes.capAb) |=> $stable(storeAb)); // R3
  AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capAb |=> (storeAb == $past(aEff))); // R4
  AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capBa |=> (storeBa == $past(bEff))); // R8
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !aDrv |=> $stable(holdA)); // R9
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !bDrv |=> $stable(holdB)); // R9
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic             aDrv,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bDrv,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe,
  input  logic             leAb,
  input  logic             clkAb,
  input  logic             oeAb,
  input  logic             leBa,
  input  logic             clkBa,
  input  logic             oeBaN
);
  xferStrobe_t strobes;

  xcvr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .leAb(leAb), .clkAb(clkAb), .leBa(leBa), .clkBa(clkBa),
    .strobes(strobes)
  );

  xcvr_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .aDrv(aDrv), .bIn(bIn), .bDrv(bDrv),
    .strobes(strobes), .aOut(aOut), .bOut(bOut)
  );

  // Direction enables fan out to every bit; opposite polarities
  assign bOe = {WIDTH{oeAb}};
  assign aOe = {WIDTH{~oeBaN}};
endmodule

// File: tb/reg_bus_xcvr_tb.sv
`timescale 1ns/1ps
module reg_bus_xcvr_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic aDrv = 1'b0, bDrv = 1'b0;
  logic leAb = 1'b0, clkAb = 1'b0, oeAb = 1'b0;
  logic leBa = 1'b0, clkBa = 1'b0, oeBaN = 1'b1;
  logic [W-1:0] aOut, aOe, bOut, bOe;

  int checks = 0;
  int fails = 0;

  // Bench model state
  logic [W-1:0] mHoldA = '0, mHoldB = '0, mStAb = '0, mStBa = '0;
  logic mPrevCkAb = 1'b0, mPrevCkBa = 1'b0;
  logic capAbLast = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  reg_bus_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .aDrv(aDrv), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bDrv(bDrv), .bOut(bOut), .bOe(bOe),
    .leAb(leAb), .clkAb(clkAb), .oeAb(oeAb),
    .leBa(leBa), .clkBa(clkBa), .oeBaN(oeBaN)
  );

  function automatic logic [W-1:0] effOf(logic drv, logic [W-1:0] raw, logic [W-1:0] hold);
    return drv ? raw : hold;
  endfunction

  function automatic logic [W-1:0] outOf(logic le, logic [W-1:0] eff, logic [W-1:0] st);
    return le ? eff : st;
  endfunction

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are already set (after a negedge); check, then advance the model
  task automatic step(string tagB, string tagA);
    logic [W-1:0] eA, eB;
    logic rA, rB;
    string tb;
    #1;
    eA = effOf(aDrv, aIn, mHoldA);
    eB = effOf(bDrv, bIn, mHoldB);
    tb = (tagB != "") ? tagB : (leAb ? "R2" : (capAbLast ? "R4" : "R3"));
    cmp(tb, bOut, outOf(leAb, eA, mStAb));
    cmp((tagA != "") ? tagA : "R8", aOut, outOf(leBa, eB, mStBa));
    cmp("R6", bOe, {W{oeAb}});
    cmp("R7", aOe, {W{~oeBaN}});
    @(posedge clk);
    rA = clkAb && !mPrevCkAb && !leAb;
    rB = clkBa && !mPrevCkBa && !leBa;
    if (leAb || rA) mStAb = eA;
    if (leBa || rB) mStBa = eB;
    if (aDrv) mHoldA = aIn;
    if (bDrv) mHoldB = bIn;
    mPrevCkAb = clkAb;
    mPrevCkBa = clkBa;
    capAbLast = rA;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7061));
    // R1: reset state
    aIn = 18'h2AAAA; bIn = 18'h15555;
    #9;
    cmp("R1", bOut, '0);
    cmp("R1", aOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    step("R1", "R1");

    // R2 / R5: transparent, then pass control falls
    aDrv = 1'b1; aIn = 18'h12345; leAb = 1'b1; oeAb = 1'b1;
    step("R2", "");
    aIn = 18'h0BEEF;
    step("R2", "");
    leAb = 1'b0; aIn = 18'h3FFFF;
    step("R5", "");
    step("R5", "");

    // R4 then R10: rising edge captures, falling edge does not
    aIn = 18'h00F0F; clkAb = 1'b1;
    step("R4", "");
    aIn = 18'h30303;
    step("R4", "");
    clkAb = 1'b0;
    step("R10", "");
    step("R10", "");

    // R9: capture while A undriven uses held level; transparent B-to-A with B released
    aIn = 18'h11111;
    step("", "");
    aDrv = 1'b0; aIn = 18'h22222; clkAb = 1'b1;
    step("R9", "");
    step("R9", "");
    bDrv = 1'b1; bIn = 18'h0CAFE; leBa = 1'b1; oeBaN = 1'b0;
    step("", "R8");
    bDrv = 1'b0; bIn = 18'h3DEAD;
    step("", "R9");
    leBa = 1'b0; clkBa = 1'b1;
    step("", "R8");
    clkBa = 1'b0; bDrv = 1'b1;
    step("", "R10");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      aIn   = W'($urandom());
      bIn   = W'($urandom());
      aDrv  = ($urandom() % 4) != 0;
      bDrv  = ($urandom() % 4) != 0;
      leAb  = ($urandom() % 4) == 0;
      leBa  = ($urandom() % 4) == 0;
      if (($urandom() % 2) == 0) clkAb = ~clkAb;
      if (($urandom() % 2) == 0) clkBa = ~clkBa;
      oeAb  = $urandom() % 2;
      oeBaN = $urandom() % 2;
      step("", "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule